// File: doc/BRIEF.md
# Saturating-Counter LRU Replacement Unit

This unit decides which way of a set-associative cache is replaced on a miss. Each way of each set owns a small usage counter whose range is set by a run-time choice of 2, 3 or 4 usage states. A high value means recent use and zero means the way is the first candidate for eviction. The surrounding cache controller compares tags and holds the data. It tells this unit about hits, fills and invalidates through one-cycle strobes, and it reads the victim way of the indexed set combinationally.

The operation decoder has four named states, evaluated every cycle from the strobes. OP_NONE holds all counters. OP_HIT applies the hit rule. OP_FILL applies the fill rule to the way currently shown on the victim output. OP_INV clears one counter. The result is written back into the row of the indexed set in the same clock edge. The configuration register moves from its current setting to a new one only on a cycle decoded as OP_NONE. It stays where it is on every other cycle.

Top module: `lru_repl_unit`

## Requirements
- R1: After reset every counter of every set is 0, the number of usage states is 4 (highest counter value 3), and victim_way reads 0 for every set.
- R2: On hit_vld for way h of the indexed set, every other way of that set whose counter is strictly greater than the old counter of h loses one, and h is set to the highest value (states minus one) at the next clock edge.
- R3: On fill_vld, every nonzero counter of the indexed set loses one, and the way shown on victim_way in that cycle is set to the highest value at the next clock edge.
- R4: victim_way is the way with the smallest counter in the indexed set, ties going to the lowest-numbered way. The search starts from the highest value and way 0 and accepts only strictly smaller counters.
- R5: On inv_vld, only the counter of inv_way in the indexed set is cleared to 0 at the next clock edge, which makes that way the victim unless a lower-numbered way also holds 0.
- R6: With cfg_wr high on a cycle with no strobe, a cfg_states value of 2, 3 or 4 (the binary number of states) becomes the number of usage states from the next clock edge on.
- R7: A cfg_states value outside 2 to 4 is ignored and leaves the previous setting. A cfg_wr on a cycle that also carries a hit, fill or invalidate strobe is also ignored and leaves the previous setting.
- R8: A cycle without a strobe leaves every counter unchanged, and an operation on one set leaves the counters of all other sets unchanged.
- R9: At most one of hit_vld, fill_vld and inv_vld is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | 3 | Set addressed by the current operation and by the victim output |
| hit_vld | input | 1 | Hit strobe for hit_way |
| hit_way | input | 2 | Way that hit |
| fill_vld | input | 1 | Fill strobe; the way filled is the current victim |
| inv_vld | input | 1 | Invalidate strobe for inv_way |
| inv_way | input | 2 | Way to invalidate |
| cfg_wr | input | 1 | Request to change the number of usage states |
| cfg_states | input | 3 | Requested number of usage states, binary |
| victim_way | output | 2 | Replacement candidate of the indexed set |

## Verification
The checker treats the three strobes as mutually exclusive and flags any cycle where two are high. Its counter checks are written on that premise. The checker also relies on the indexed set and the way inputs being stable during the cycle that carries a strobe. The bench drives every operation through tasks that raise exactly one strobe for one cycle and change set_idx only between operations. The single cycle that pairs cfg_wr with a hit is still legal, because cfg_wr is not one of the exclusive strobes.

// File: rtl/lru_pkg.sv
`timescale 1ns/1ps
package lru_pkg;

    // Operation decoded from the strobes for the current cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2,
        OP_INV  = 2'd3
    } lru_op_e;

endpackage

// File: rtl/lru_cfg.sv
`timescale 1ns/1ps
// Holds the highest counter value (usage states minus one).
module lru_cfg #(
    parameter int CNT_W      = 2,
    parameter int DEF_STATES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W:0]   cfg_states,
    input  logic             busy,
    output logic [CNT_W-1:0] top_o
);
    localparam int MAX_STATES = 1 << CNT_W;
    localparam logic [CNT_W-1:0] DEF_TOP = CNT_W'(DEF_STATES - 1);

    logic             take;
    logic [CNT_W-1:0] top_q;

    always_comb begin
        take = cfg_wr && !busy
            && (int'(cfg_states) >= 2)
            && (int'(cfg_states) <= MAX_STATES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= DEF_TOP;
        end else if (take) begin
            top_q <= CNT_W'(cfg_states - 1'b1);
        end
    end

    assign top_o = top_q;

endmodule

// File: rtl/lru_victim.sv
`timescale 1ns/1ps
// Smallest-counter search; only strictly smaller values replace the candidate.
module lru_victim #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 2,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS*CNT_W-1:0] row_i,
    input  logic [CNT_W-1:0]          top_i,
    output logic [WAY_W-1:0]          victim_o
);
    logic [CNT_W-1:0] best;

    always_comb begin
        best     = top_i;
        victim_o = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (row_i[w*CNT_W +: CNT_W] < best) begin
                best     = row_i[w*CNT_W +: CNT_W];
                victim_o = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/lru_next.sv
`timescale 1ns/1ps
// Next-value logic for one set's row of counters.
module lru_next
    import lru_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 2,
    parameter int WAY_W    = 2
) (
    input  lru_op_e                   op_i,
    input  logic [NUM_WAYS*CNT_W-1:0] row_i,
    input  logic [WAY_W-1:0]          hit_way_i,
    input  logic [WAY_W-1:0]          fill_way_i,
    input  logic [WAY_W-1:0]          inv_way_i,
    input  logic [CNT_W-1:0]          top_i,
    output logic [NUM_WAYS*CNT_W-1:0] row_o
);
    logic [CNT_W-1:0] ref_cnt;

    always_comb begin
        row_o   = row_i;
        ref_cnt = row_i[hit_way_i*CNT_W +: CNT_W];
        unique case (op_i)
            OP_HIT: begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if ((w != int'(hit_way_i)) && (row_i[w*CNT_W +: CNT_W] > ref_cnt)) begin
                        row_o[w*CNT_W +: CNT_W] = row_i[w*CNT_W +: CNT_W] - 1'b1;
                    end
                end
                row_o[hit_way_i*CNT_W +: CNT_W] = top_i;
            end
            OP_FILL: begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (row_i[w*CNT_W +: CNT_W] != '0) begin
                        row_o[w*CNT_W +: CNT_W] = row_i[w*CNT_W +: CNT_W] - 1'b1;
                    end
                end
                row_o[fill_way_i*CNT_W +: CNT_W] = top_i;
            end
            OP_INV: begin
                row_o[inv_way_i*CNT_W +: CNT_W] = '0;
            end
            OP_NONE: begin
                row_o = row_i;
            end
            default: begin
                row_o = row_i;
            end
        endcase
    end

endmodule

// File: rtl/lru_repl_unit.sv
`timescale 1ns/1ps
// Counter-based approximate-LRU replacement unit.
module lru_repl_unit
    import lru_pkg::*;
#(
    parameter int NUM_SETS   = 8,
    parameter int NUM_WAYS   = 4,
    parameter int CNT_W      = 2,
    parameter int DEF_STATES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_SETS)-1:0]  set_idx,
    input  logic                         hit_vld,
    input  logic [$clog2(NUM_WAYS)-1:0]  hit_way,
    input  logic                         fill_vld,
    input  logic                         inv_vld,
    input  logic [$clog2(NUM_WAYS)-1:0]  inv_way,
    input  logic                         cfg_wr,
    input  logic [CNT_W:0]               cfg_states,
    output logic [$clog2(NUM_WAYS)-1:0]  victim_way
);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int ROW_W  = NUM_WAYS * CNT_W;
    localparam int FLAT_W = NUM_SETS * ROW_W;

    lru_op_e          op;
    logic [CNT_W-1:0] top_val;
    logic [ROW_W-1:0] row_q [NUM_SETS];
    logic [ROW_W-1:0] row_rd;
    logic [ROW_W-1:0] row_nxt;
    logic [FLAT_W-1:0] cnt_flat;

    // Strobe decode: the strobes are exclusive, priority only resolves misuse
    always_comb begin
        if (hit_vld)       op = OP_HIT;
        else if (fill_vld) op = OP_FILL;
        else if (inv_vld)  op = OP_INV;
        else               op = OP_NONE;
    end

    lru_cfg #(
        .CNT_W      (CNT_W),
        .DEF_STATES (DEF_STATES)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_states (cfg_states),
        .busy       (op != OP_NONE),
        .top_o      (top_val)
    );

    assign row_rd = row_q[set_idx];

    lru_victim #(
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W),
        .WAY_W    (WAY_W)
    ) u_victim (
        .row_i    (row_rd),
        .top_i    (top_val),
        .victim_o (victim_way)
    );

    lru_next #(
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W),
        .WAY_W    (WAY_W)
    ) u_next (
        .op_i       (op),
        .row_i      (row_rd),
        .hit_way_i  (hit_way),
        .fill_way_i (victim_way),
        .inv_way_i  (inv_way),
        .top_i      (top_val),
        .row_o      (row_nxt)
    );

    // One row register per set, written only when its set is addressed
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic wr_en;
        assign wr_en = (op != OP_NONE) && (set_idx == SET_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q[s] <= '0;
            end else if (wr_en) begin
                row_q[s] <= row_nxt;
            end
        end

        assign cnt_flat[s*ROW_W +: ROW_W] = row_q[s];
    end

endmodule

// File: rtl/lru_repl_chk.sv
`timescale 1ns/1ps
module lru_repl_chk #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [$clog2(NUM_SETS)-1:0]        set_idx,
    input logic                               hit_vld,
    input logic [$clog2(NUM_WAYS)-1:0]        hit_way,
    input logic                               fill_vld,
    input logic                               inv_vld,
    input logic [$clog2(NUM_WAYS)-1:0]        inv_way,
    input logic [$clog2(NUM_WAYS)-1:0]        victim_way,
    input logic [CNT_W-1:0]                   top_val,
    input logic [NUM_SETS*NUM_WAYS*CNT_W-1:0] cnt_flat
);
    function automatic logic [CNT_W-1:0] cnt_at(int s, int w);
        return cnt_flat[(s*NUM_WAYS + w)*CNT_W +: CNT_W];
    endfunction

    // R9
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hit_vld, fill_vld, inv_vld}) <= 1);

    // R2
    hit_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> cnt_at(int'($past(set_idx)), int'($past(hit_way))) == $past(top_val));

    // R3
    fill_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> cnt_at(int'($past(set_idx)), int'($past(victim_way))) == $past(top_val));

    // R5
    inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_vld |=> cnt_at(int'($past(set_idx)), int'($past(inv_way))) == '0);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_vld || fill_vld || inv_vld) |=> $stable(cnt_flat));

    // R6
    top_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_val >= CNT_W'(1));

endmodule

bind lru_repl_unit lru_repl_chk #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (set_idx),
    .hit_vld    (hit_vld),
    .hit_way    (hit_way),
    .fill_vld   (fill_vld),
    .inv_vld    (inv_vld),
    .inv_way    (inv_way),
    .victim_way (victim_way),
    .top_val    (top_val),
    .cnt_flat   (cnt_flat)
);

// File: tb/sim_lru_repl_unit.sv
`timescale 1ns/1ps
module sim_lru_repl_unit;
    localparam int NS = 8;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] set_idx = '0;
    logic       hit_vld = 1'b0;
    logic [1:0] hit_way = '0;
    logic       fill_vld = 1'b0;
    logic       inv_vld = 1'b0;
    logic [1:0] inv_way = '0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_states = '0;
    logic [1:0] victim_way;

    int checks = 0;
    int bad = 0;
    int m [NS][NW];
    int top_m = 3;

    always #10 clk = ~clk;

    lru_repl_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (set_idx),
        .hit_vld    (hit_vld),
        .hit_way    (hit_way),
        .fill_vld   (fill_vld),
        .inv_vld    (inv_vld),
        .inv_way    (inv_way),
        .cfg_wr     (cfg_wr),
        .cfg_states (cfg_states),
        .victim_way (victim_way)
    );

    function automatic int mvict(int s);
        int best = top_m;
        int v = 0;
        for (int w = 0; w < NW; w++) begin
            if (m[s][w] < best) begin
                best = m[s][w];
                v = w;
            end
        end
        return v;
    endfunction

    task automatic check_vic(int s, string tag);
        @(negedge clk);
        set_idx = 3'(s);
        #2;
        checks++;
        if (int'(victim_way) != mvict(s)) begin
            bad++;
            $display("FAIL %s set=%0d victim actual=%0d expected=%0d", tag, s, victim_way, mvict(s));
        end
    endtask

    task automatic op_hit(int s, int w);
        int old = m[s][w];
        for (int i = 0; i < NW; i++)
            if (i != w && m[s][i] > old) m[s][i]--;
        m[s][w] = top_m;
        @(negedge clk);
        set_idx = 3'(s); hit_way = 2'(w); hit_vld = 1'b1;
        @(negedge clk);
        hit_vld = 1'b0;
    endtask

    task automatic op_fill(int s);
        int v = mvict(s);
        for (int i = 0; i < NW; i++)
            if (m[s][i] != 0) m[s][i]--;
        m[s][v] = top_m;
        @(negedge clk);
        set_idx = 3'(s); fill_vld = 1'b1;
        @(negedge clk);
        fill_vld = 1'b0;
    endtask

    task automatic op_inv(int s, int w);
        m[s][w] = 0;
        @(negedge clk);
        set_idx = 3'(s); inv_way = 2'(w); inv_vld = 1'b1;
        @(negedge clk);
        inv_vld = 1'b0;
    endtask

    task automatic op_cfg(int n);
        if (n >= 2 && n <= 4) top_m = n - 1;
        @(negedge clk);
        cfg_states = 3'(n); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_set(int s);
        for (int w = 0; w < NW; w++) op_inv(s, w);
    endtask

    // R1: reset state
    task automatic t_reset();
        for (int s = 0; s < NS; s++) check_vic(s, "R1 reset");
    endtask

    // R3: fill sequence on an empty set, victims 1,2,3,0
    task automatic t_fill();
        for (int k = 0; k < 4; k++) begin
            op_fill(1);
            check_vic(1, "R3 fill");
        end
    endtask

    // R2: hits with various old counter values
    task automatic t_hit();
        op_hit(1, 2); check_vic(1, "R2 hit");
        op_hit(1, 0); check_vic(1, "R2 hit");
        op_hit(1, 3); check_vic(1, "R2 hit");
        op_hit(1, 3); check_vic(1, "R2 hit repeat");
    endtask

    // R4: ties resolve to the lowest way
    task automatic t_ties();
        op_fill(2); check_vic(2, "R4 tie");
        op_hit(2, 3); check_vic(2, "R4 tie");
        op_hit(2, 1); check_vic(2, "R4 tie");
    endtask

    // R5: invalidate clears one way only
    task automatic t_inv();
        op_inv(1, 3); check_vic(1, "R5 inv");
        op_hit(1, 3); check_vic(1, "R5 inv");
        op_inv(1, 1); check_vic(1, "R5 inv");
    endtask

    // R8: idle cycles and other sets untouched
    task automatic t_idle();
        op_fill(5);
        op_fill(5);
        repeat (5) @(negedge clk);
        check_vic(5, "R8 idle");
        check_vic(1, "R8 idle");
        op_hit(1, 0); op_inv(1, 2); op_fill(1);
        check_vic(5, "R8 isolation");
        check_vic(2, "R8 isolation");
    endtask

    // R6: two and three states
    task automatic t_cfg();
        op_cfg(2);
        clear_set(3);
        op_fill(3); check_vic(3, "R6 states2");
        op_fill(3); check_vic(3, "R6 states2");
        op_hit(3, 2); check_vic(3, "R6 states2");
        op_cfg(3);
        clear_set(3);
        op_fill(3); op_fill(3); check_vic(3, "R6 states3");
        op_fill(3); check_vic(3, "R6 states3");
        op_hit(3, 0); check_vic(3, "R6 states3");
    endtask

    // R7: out-of-range and busy-cycle requests ignored (setting stays at 3 states)
    task automatic t_cfg_bad();
        op_cfg(5);
        op_cfg(1);
        op_cfg(0);
        op_cfg(7);
        // request 2 states together with a hit: must be ignored
        begin
            int old = m[4][0];
            for (int i = 1; i < NW; i++) if (m[4][i] > old) m[4][i]--;
            m[4][0] = top_m;
            @(negedge clk);
            set_idx = 3'd4; hit_way = 2'd0; hit_vld = 1'b1;
            cfg_states = 3'd2; cfg_wr = 1'b1;
            @(negedge clk);
            hit_vld = 1'b0; cfg_wr = 1'b0;
        end
        clear_set(4);
        op_fill(4); check_vic(4, "R7 ignored");
        op_fill(4); check_vic(4, "R7 ignored");
        op_fill(4); check_vic(4, "R7 ignored");
    endtask

    // R4/R2: counters above a lowered highest value
    task automatic t_lowered();
        op_cfg(4);
        clear_set(6);
        for (int k = 0; k < 4; k++) op_fill(6);
        op_hit(6, 0);
        op_cfg(2);
        check_vic(6, "R4 lowered");
        op_hit(6, 1); check_vic(6, "R2 lowered");
        op_hit(6, 2); check_vic(6, "R2 lowered");
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) m[s][w] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_hit();
        t_ties();
        t_inv();
        t_idle();
        t_cfg();
        t_cfg_bad();
        t_lowered();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule